// File: doc/BRIEF.md
# Float-to-Unsigned Truncating Converter

This block turns a 32-bit IEEE-754 single-precision operand into a 32-bit unsigned integer, always discarding the fractional part. No rounding-mode control exists. A fixed truncation toward zero is the only behaviour. Operands that are not finite, negative, or too large are mapped by category to either zero or all-ones. Each mapping raises one of three exception flags: invalid, inexact or input-flushed-to-zero. Subnormal operands are treated as zero and raise the flush flag.

Each issued operand carries a guard bit and a mode select. When the guard is clear, the operation is dropped: no destination write and no flag update. In the flags-only mode, the result word carries the flag bits that the conversion would raise, and the data value is discarded. In that mode the sticky-flag write-enable stays low. The unit is fully pipelined. It accepts one operand per cycle and returns each result three rising edges after the edge that samples it.

Top module: `fcvt_ftou_trunc`

## Requirements
- R1: A positive normal operand below 2^32 yields the integer part of its value. The inexact flag (flag bit 1) is raised exactly when a nonzero fraction was discarded.
- R2: A positive normal operand strictly between 0 and 1 yields 0 with only the inexact flag. Positive zero and negative zero yield 0 with no flag.
- R3: A subnormal operand of either sign yields 0 with only the flush flag (flag bit 2).
- R4: A negative normal operand or negative infinity yields 0 with only the invalid flag (flag bit 0).
- R5: Any NaN operand, quiet or signalling, of either sign, yields 0 with only the invalid flag.
- R6: Positive infinity, and every finite positive operand of 2^32 or more, yield 0xFFFFFFFF with only the invalid flag.
- R7: At most one bit of the flag vector `o_flags` is ever set. `o_flags` is all zero whenever `o_flag_we` is low.
- R8: An operand sampled with `i_valid` high at a rising edge produces `o_valid` high after the third rising edge counted from that one. Back-to-back operands emerge in order, one per cycle.
- R9: With `i_guard` low, `o_dst_we` and `o_flag_we` are low and `o_flags` is zero for that operation.
- R10: With `i_flags_only` high and `i_guard` high, `o_result` equals the flag bits in positions [2:0] with all higher bits zero. In that case `o_dst_we` is high and `o_flag_we` is low.
- R11: While and right after synchronous reset, `o_valid`, `o_dst_we`, `o_flag_we`, `o_flags` and `o_result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| i_valid | input | 1 | Operand issue strobe |
| i_operand | input | 32 | Single-precision operand |
| i_guard | input | 1 | Operation takes effect when high |
| i_flags_only | input | 1 | Return flag bits as the result instead of the integer |
| o_valid | output | 1 | Result strobe |
| o_result | output | 32 | Integer result or flag word |
| o_flags | output | 3 | Sticky-flag update: bit 0 invalid, bit 1 inexact, bit 2 flushed |
| o_dst_we | output | 1 | Destination write-enable |
| o_flag_we | output | 1 | Sticky-flag write-enable |

## Verification
The hardest point to reach from the ports is the boundary of the shifter. At the top, the largest finite operand below 2^32 must still convert exactly, while 2^32 itself must saturate. At the bottom, a value just under 1 must drop every significand bit and raise inexact. Directed operands pin the exponent at each side of these limits: 0x4F7FFFFF, 0x4F800000, 0x4F000000 and 0x3F7FFFFF. Neighbours whose low significand bits are set or clear separate exact results from inexact ones. A back-to-back stream of mixed categories then checks that the per-stage category and guard/mode state travel with their operand through the pipeline.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
  typedef enum logic [2:0] {
    CAT_ZERO,
    CAT_FLUSH,
    CAT_INVZ,
    CAT_SAT,
    CAT_FRAC,
    CAT_NUM
  } fcvt_cat_e;

  localparam int FLAG_W  = 3;
  localparam int FLG_INV = 0;
  localparam int FLG_INX = 1;
  localparam int FLG_FTZ = 2;
endpackage

// File: rtl/fcvt_classify.sv
module fcvt_classify
  import fcvt_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32,
  localparam int OP_W = EXP_W + MAN_W + 1,
  localparam int SH_W = $clog2(INT_W)
) (
  input  logic [OP_W-1:0]  op,
  output fcvt_cat_e        cat,
  output logic [MAN_W:0]   sig,
  output logic [SH_W-1:0]  shamt
);
  localparam int UE_W = EXP_W + 2;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  logic             sgn;
  logic [EXP_W-1:0] ex;
  logic [MAN_W-1:0] man;
  logic signed [UE_W-1:0] ue;

  assign sgn = op[OP_W-1];
  assign ex  = op[OP_W-2 -: EXP_W];
  assign man = op[MAN_W-1:0];
  assign ue  = signed'({2'b00, ex}) - signed'(UE_W'(BIAS));
  assign sig = {1'b1, man};
  assign shamt = ue[SH_W-1:0];

  always_comb begin
    if (ex == '1) begin
      if (man != '0)   cat = CAT_INVZ;
      else if (sgn)    cat = CAT_INVZ;
      else             cat = CAT_SAT;
    end else if (ex == '0) begin
      cat = (man != '0) ? CAT_FLUSH : CAT_ZERO;
    end else if (sgn) begin
      cat = CAT_INVZ;
    end else if (ue < 0) begin
      cat = CAT_FRAC;
    end else if (ue >= signed'(UE_W'(INT_W))) begin
      cat = CAT_SAT;
    end else begin
      cat = CAT_NUM;
    end
  end
endmodule

// File: rtl/fcvt_shift.sv
module fcvt_shift #(
  parameter int MAN_W = 23,
  parameter int INT_W = 32,
  localparam int SH_W = $clog2(INT_W),
  localparam int WIDE = INT_W + MAN_W
) (
  input  logic [MAN_W:0]   sig,
  input  logic [SH_W-1:0]  shamt,
  output logic [INT_W-1:0] ival,
  output logic             frac_nz
);
  logic [WIDE-1:0] wide;

  assign wide    = {{(INT_W-1){1'b0}}, sig} << shamt;
  assign ival    = wide[MAN_W +: INT_W];
  assign frac_nz = |wide[MAN_W-1:0];
endmodule

// File: rtl/fcvt_outstage.sv
module fcvt_outstage
  import fcvt_pkg::*;
#(
  parameter int INT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s_valid,
  input  logic             s_guard,
  input  logic             s_flags_only,
  input  fcvt_cat_e        s_cat,
  input  logic [INT_W-1:0] s_ival,
  input  logic             s_frac_nz,
  output logic             o_valid,
  output logic [INT_W-1:0] o_result,
  output logic [FLAG_W-1:0] o_flags,
  output logic             o_dst_we,
  output logic             o_flag_we
);
  logic [INT_W-1:0]  val;
  logic [FLAG_W-1:0] fl;
  logic              upd_flags;

  always_comb begin
    val = '0;
    fl  = '0;
    case (s_cat)
      CAT_FLUSH: fl[FLG_FTZ] = 1'b1;
      CAT_INVZ:  fl[FLG_INV] = 1'b1;
      CAT_SAT: begin
        val = '1;
        fl[FLG_INV] = 1'b1;
      end
      CAT_FRAC:  fl[FLG_INX] = 1'b1;
      CAT_NUM: begin
        val = s_ival;
        fl[FLG_INX] = s_frac_nz;
      end
      default: ;
    endcase
  end

  assign upd_flags = s_valid & s_guard & ~s_flags_only;

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid   <= 1'b0;
      o_result  <= '0;
      o_flags   <= '0;
      o_dst_we  <= 1'b0;
      o_flag_we <= 1'b0;
    end else begin
      o_valid   <= s_valid;
      o_result  <= s_flags_only ? {{(INT_W-FLAG_W){1'b0}}, fl} : val;
      o_flags   <= upd_flags ? fl : '0;
      o_dst_we  <= s_valid & s_guard;
      o_flag_we <= upd_flags;
    end
  end
endmodule

// File: rtl/fcvt_ftou_trunc.sv
module fcvt_ftou_trunc
  import fcvt_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  parameter int INT_W = 32,
  localparam int OP_W = EXP_W + MAN_W + 1,
  localparam int SH_W = $clog2(INT_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              i_valid,
  input  logic [OP_W-1:0]   i_operand,
  input  logic              i_guard,
  input  logic              i_flags_only,
  output logic              o_valid,
  output logic [INT_W-1:0]  o_result,
  output logic [FLAG_W-1:0] o_flags,
  output logic              o_dst_we,
  output logic              o_flag_we
);
  // stage 1: classification
  fcvt_cat_e        c_cat;
  logic [MAN_W:0]   c_sig;
  logic [SH_W-1:0]  c_shamt;

  fcvt_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) u_cls (
    .op(i_operand), .cat(c_cat), .sig(c_sig), .shamt(c_shamt)
  );

  logic             s1_valid, s1_guard, s1_mode;
  fcvt_cat_e        s1_cat;
  logic [MAN_W:0]   s1_sig;
  logic [SH_W-1:0]  s1_shamt;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_guard <= 1'b0;
      s1_mode  <= 1'b0;
      s1_cat   <= CAT_ZERO;
      s1_sig   <= '0;
      s1_shamt <= '0;
    end else begin
      s1_valid <= i_valid;
      s1_guard <= i_guard;
      s1_mode  <= i_flags_only;
      s1_cat   <= c_cat;
      s1_sig   <= c_sig;
      s1_shamt <= c_shamt;
    end
  end

  // stage 2: alignment
  logic [INT_W-1:0] a_ival;
  logic             a_frac_nz;

  fcvt_shift #(.MAN_W(MAN_W), .INT_W(INT_W)) u_shf (
    .sig(s1_sig), .shamt(s1_shamt), .ival(a_ival), .frac_nz(a_frac_nz)
  );

  logic             s2_valid, s2_guard, s2_mode, s2_frac_nz;
  fcvt_cat_e        s2_cat;
  logic [INT_W-1:0] s2_ival;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_valid   <= 1'b0;
      s2_guard   <= 1'b0;
      s2_mode    <= 1'b0;
      s2_cat     <= CAT_ZERO;
      s2_ival    <= '0;
      s2_frac_nz <= 1'b0;
    end else begin
      s2_valid   <= s1_valid;
      s2_guard   <= s1_guard;
      s2_mode    <= s1_mode;
      s2_cat     <= s1_cat;
      s2_ival    <= a_ival;
      s2_frac_nz <= a_frac_nz;
    end
  end

  // stage 3: result and flag selection
  fcvt_outstage #(.INT_W(INT_W)) u_out (
    .clk(clk), .rst(rst),
    .s_valid(s2_valid), .s_guard(s2_guard), .s_flags_only(s2_mode),
    .s_cat(s2_cat), .s_ival(s2_ival), .s_frac_nz(s2_frac_nz),
    .o_valid(o_valid), .o_result(o_result), .o_flags(o_flags),
    .o_dst_we(o_dst_we), .o_flag_we(o_flag_we)
  );
endmodule

// File: rtl/fcvt_ftou_trunc_chk.sv
module fcvt_ftou_trunc_chk #(
  parameter int INT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             i_valid,
  input logic             o_valid,
  input logic [INT_W-1:0] o_result,
  input logic [2:0]       o_flags,
  input logic             o_dst_we,
  input logic             o_flag_we
);
  logic [2:0] vpipe;

  always_ff @(posedge clk) begin
    if (rst) vpipe <= '0;
    else     vpipe <= {vpipe[1:0], i_valid};
  end

  assert_latency_R8: assert property (@(posedge clk) disable iff (rst)
    o_valid == vpipe[2]);

  assert_flags_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(o_flags));

  assert_flags_gated_R7: assert property (@(posedge clk) disable iff (rst)
    !o_flag_we |-> (o_flags == '0));

  assert_we_needs_valid_R9: assert property (@(posedge clk) disable iff (rst)
    !o_valid |-> (!o_dst_we && !o_flag_we));

  assert_flag_we_needs_dst_R10: assert property (@(posedge clk) disable iff (rst)
    o_flag_we |-> o_dst_we);

  assert_sat_invalid_R6: assert property (@(posedge clk) disable iff (rst)
    (o_flag_we && o_result == '1) |-> o_flags[0]);

  assert_reset_quiet_R11: assert property (@(posedge clk)
    $past(rst) |-> (!o_valid && !o_dst_we && !o_flag_we));
endmodule

bind fcvt_ftou_trunc fcvt_ftou_trunc_chk #(.INT_W(INT_W)) u_chk (
  .clk(clk), .rst(rst), .i_valid(i_valid), .o_valid(o_valid),
  .o_result(o_result), .o_flags(o_flags), .o_dst_we(o_dst_we),
  .o_flag_we(o_flag_we)
);

// File: tb/test_fcvt_ftou_trunc.sv
module test_fcvt_ftou_trunc;
  logic        clk = 1'b0;
  logic        rst;
  logic        i_valid, i_guard, i_flags_only;
  logic [31:0] i_operand;
  logic        o_valid, o_dst_we, o_flag_we;
  logic [31:0] o_result;
  logic [2:0]  o_flags;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  localparam logic [2:0] F_NONE = 3'b000;
  localparam logic [2:0] F_INV  = 3'b001;
  localparam logic [2:0] F_INX  = 3'b010;
  localparam logic [2:0] F_FTZ  = 3'b100;

  always #10 clk = ~clk;  // 50 MHz

  fcvt_ftou_trunc i_fcvt_ftou_trunc (
    .clk(clk), .rst(rst), .i_valid(i_valid), .i_operand(i_operand),
    .i_guard(i_guard), .i_flags_only(i_flags_only), .o_valid(o_valid),
    .o_result(o_result), .o_flags(o_flags), .o_dst_we(o_dst_we),
    .o_flag_we(o_flag_we)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
    end
  endtask

  task automatic expect_out(input string req, input logic [31:0] res,
                            input logic [2:0] fl, input bit dwe, input bit fwe);
    chk(o_valid == 1'b1, req, "valid", 32'(o_valid), 32'd1);
    chk(o_result == res, req, "result", o_result, res);
    chk(o_flags == fl, req, "flags", 32'(o_flags), 32'(fl));
    chk(o_dst_we == dwe, req, "dst_we", 32'(o_dst_we), 32'(dwe));
    chk(o_flag_we == fwe, req, "flag_we", 32'(o_flag_we), 32'(fwe));
  endtask

  // issue one operand, result is visible after the third rising edge
  task automatic run_one(input string req, input logic [31:0] op, input bit g,
                         input bit fo, input logic [31:0] res,
                         input logic [2:0] fl, input bit dwe, input bit fwe);
    @(negedge clk);
    i_valid = 1'b1; i_operand = op; i_guard = g; i_flags_only = fo;
    @(negedge clk);
    i_valid = 1'b0; i_operand = '0; i_guard = 1'b0; i_flags_only = 1'b0;
    chk(o_valid == 1'b0, "R8", "early valid", 32'(o_valid), 32'd0);
    @(negedge clk);
    chk(o_valid == 1'b0, "R8", "early valid", 32'(o_valid), 32'd0);
    @(negedge clk);
    expect_out(req, res, fl, dwe, fwe);
  endtask

  task automatic conv(input string req, input logic [31:0] op,
                      input logic [31:0] res, input logic [2:0] fl);
    run_one(req, op, 1'b1, 1'b0, res, fl, 1'b1, fl != F_NONE || 1'b1);
  endtask

  task automatic t_reset;
    rst = 1'b1; i_valid = 1'b0; i_operand = '0; i_guard = 1'b0; i_flags_only = 1'b0;
    repeat (3) @(negedge clk);
    chk(o_valid == 1'b0 && o_dst_we == 1'b0 && o_flag_we == 1'b0, "R11",
        "strobes in reset", {29'd0, o_valid, o_dst_we, o_flag_we}, 32'd0);
    chk(o_result == '0 && o_flags == '0, "R11", "data in reset", o_result, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(o_valid == 1'b0, "R11", "valid after reset", 32'(o_valid), 32'd0);
  endtask

  task automatic t_truncate;
    conv("R1", 32'h40400000, 32'd3, F_NONE);           // 3.0
    conv("R1", 32'h40247AE1, 32'd2, F_INX);            // 2.57
    conv("R1", 32'h3F800000, 32'd1, F_NONE);           // 1.0
    conv("R1", 32'h3FC00000, 32'd1, F_INX);            // 1.5
    conv("R1", 32'h4B800001, 32'h01000002, F_NONE);    // 2^24+2
    conv("R1", 32'h4F000000, 32'h80000000, F_NONE);    // 2^31
    conv("R1", 32'h4F7FFFFF, 32'hFFFFFF00, F_NONE);    // largest below 2^32
  endtask

  task automatic t_small_zero;
    conv("R2", 32'h3F000000, 32'd0, F_INX);            // 0.5
    conv("R2", 32'h3F7FFFFF, 32'd0, F_INX);            // just under 1
    conv("R2", 32'h00800000, 32'd0, F_INX);            // smallest normal
    conv("R2", 32'h00000000, 32'd0, F_NONE);
    conv("R2", 32'h80000000, 32'd0, F_NONE);
  endtask

  task automatic t_flush;
    conv("R3", 32'h00400000, 32'd0, F_FTZ);
    conv("R3", 32'h80000001, 32'd0, F_FTZ);
    conv("R3", 32'h007FFFFF, 32'd0, F_FTZ);
  endtask

  task automatic t_negative;
    conv("R4", 32'hBFC147AE, 32'd0, F_INV);            // -1.51
    conv("R4", 32'hFF7FFFFF, 32'd0, F_INV);            // most negative finite
    conv("R4", 32'hBF000000, 32'd0, F_INV);            // -0.5
    conv("R4", 32'hFF800000, 32'd0, F_INV);            // -inf
  endtask

  task automatic t_nan;
    conv("R5", 32'h7FC00000, 32'd0, F_INV);
    conv("R5", 32'h7FA00000, 32'd0, F_INV);
    conv("R5", 32'hFFFFFFFF, 32'd0, F_INV);
    conv("R5", 32'hFFBFFFFF, 32'd0, F_INV);
  endtask

  task automatic t_saturate;
    conv("R6", 32'h7F800000, 32'hFFFFFFFF, F_INV);     // +inf
    conv("R6", 32'h4F800000, 32'hFFFFFFFF, F_INV);     // 2^32
    conv("R6", 32'h7F7FFFFF, 32'hFFFFFFFF, F_INV);     // largest finite
  endtask

  task automatic t_guard;
    run_one("R9", 32'hFF7FFFFF, 1'b0, 1'b0, 32'd0, F_NONE, 1'b0, 1'b0);
    run_one("R9", 32'h40247AE1, 1'b0, 1'b0, 32'd2, F_NONE, 1'b0, 1'b0);
    run_one("R9", 32'h7F800000, 1'b0, 1'b1, 32'd1, F_NONE, 1'b0, 1'b0);
  endtask

  task automatic t_flags_only;
    run_one("R10", 32'h40247AE1, 1'b1, 1'b1, 32'h2, F_NONE, 1'b1, 1'b0);
    run_one("R10", 32'h7FC00000, 1'b1, 1'b1, 32'h1, F_NONE, 1'b1, 1'b0);
    run_one("R10", 32'h00400000, 1'b1, 1'b1, 32'h4, F_NONE, 1'b1, 1'b0);
    run_one("R10", 32'h40400000, 1'b1, 1'b1, 32'h0, F_NONE, 1'b1, 1'b0);
  endtask

  // back-to-back stream; item c is checked at negedge c+3
  task automatic t_stream;
    logic [31:0] ops [6];
    logic [31:0] ress[6];
    logic [2:0]  fls [6];
    bit          gds [6];
    ops[0] = 32'h40400000; ress[0] = 32'd3;          fls[0] = F_NONE; gds[0] = 1'b1;
    ops[1] = 32'h7F800000; ress[1] = 32'hFFFFFFFF;   fls[1] = F_INV;  gds[1] = 1'b1;
    ops[2] = 32'h3F000000; ress[2] = 32'd0;          fls[2] = F_INX;  gds[2] = 1'b1;
    ops[3] = 32'hBFC147AE; ress[3] = 32'd0;          fls[3] = F_NONE; gds[3] = 1'b0;
    ops[4] = 32'h00400000; ress[4] = 32'd0;          fls[4] = F_FTZ;  gds[4] = 1'b1;
    ops[5] = 32'h4F000000; ress[5] = 32'h80000000;   fls[5] = F_NONE; gds[5] = 1'b1;
    for (int c = 0; c < 9; c++) begin
      @(negedge clk);
      if (c >= 3) expect_out("R8", ress[c-3], fls[c-3], gds[c-3], gds[c-3]);
      if (c < 6) begin
        i_valid = 1'b1; i_operand = ops[c]; i_guard = gds[c]; i_flags_only = 1'b0;
      end else begin
        i_valid = 1'b0; i_operand = '0; i_guard = 1'b0;
      end
    end
    @(negedge clk);
    chk(o_valid == 1'b0, "R8", "valid after stream", 32'(o_valid), 32'd0);
  endtask

  initial begin
    t_reset();
    t_truncate();
    t_small_zero();
    t_flush();
    t_negative();
    t_nan();
    t_saturate();
    t_guard();
    t_flags_only();
    t_stream();
    done = 1'b1;
  end

  initial begin
    for (int k = 0; k < 200000 && !done; k++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule